// File: doc/BRIEF.md
# Two-Wire Serial Configuration Register Slave

This block is a slave on a two-wire serial bus. It holds a bank of byte-wide configuration registers that an external bus master can write and read. Both bus lines are sampled on the system clock, passed through a synchronizer, and edge-detected before any decoding. The slave drives the data line only through an open-drain pull-down enable. The whole register bank is presented as one flat vector, so the surrounding logic can use any setting directly.

A frame starts with a start condition and a first byte made of the 7-bit device address (MSB first) and a direction bit. A write frame then carries a register pointer byte and any number of data bytes. Each data byte goes to the pointer and then advances it, and the pointer wraps from the top address back to zero. A read is a write frame that sets the pointer, followed by a repeated start and the device address with the direction bit set. The slave then streams successive registers for as long as the master acknowledges. The storage is volatile and clears to zero on reset. The block has no stream interface, so all pins are plain control and data pins with no back-pressure.

Top module: `twr_regslave`

## Requirements
- R1: After reset, every register reads zero and the slave does not pull the data line low.
- R2: A start condition is the data line falling while the clock line is high, and a stop condition is the data line rising while the clock line is high. A start at any point aborts the current frame, releases the data line and begins a new device-address byte. A stop returns the slave to idle.
- R3: The first byte after a start holds the device address 1101001 (0x69) in bits 7..1 and the direction in bit 0, where 0 means write and 1 means read. On a match, the slave pulls the data line low during the ninth clock pulse. On any other address it does not acknowledge and ignores the bus until the next start.
- R4: In a write frame, the second byte loads the register pointer and each following byte is stored in the register at the pointer. The slave acknowledges every byte in the ninth clock pulse.
- R5: After each stored or transmitted byte the pointer advances by one, wrapping from 0xFF to 0x00.
- R6: In a read frame, the slave sends the register at the pointer MSB first, one bit per clock pulse, and sends the next register after each master acknowledge (data line low in the ninth pulse).
- R7: A master non-acknowledge (data line high in the ninth pulse) after a read byte makes the slave release the data line and stay off the bus until the next start or stop.
- R8: The slave changes its pull-down enable only after a falling edge of the clock line, or after a start or stop, so its output never changes while the clock line is high.
- R9: A byte cut short by a stop or start is discarded. Registers not addressed by a completed byte keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| regs_flat | output | 2048 | Register k at bits [8k+7:8k] |

## Verification
Several properties are checked on every cycle by the assertions. The pull-down enable may only change after a clock-line fall or a bus condition. A start always returns the sequencer to the address byte with the line released. Each stored byte lands at the pointer, and the pointer then steps by one modulo 256. A master non-acknowledge always releases the line. The bench scenarios cover what needs whole frames. These are: address matching across all 128 device addresses, a full 256-register burst, pointer wrap at the top of the map, reads that cross the wrap with acknowledge and non-acknowledge, and frames aborted in the middle of a byte.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEVACK,
    ST_REG,
    ST_REGACK,
    ST_WR,
    ST_WRACK,
    ST_RD,
    ST_MACK,
    ST_IGNORE
  } twr_state_e;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_now, sda_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_now   = scl_q[STAGES-1];
  assign sda_now   = sda_q[STAGES-1];
  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_d;
  assign scl_fall  = ~scl_now & scl_d;
  assign start_det = scl_now & scl_d & sda_d & ~sda_now;
  assign stop_det  = scl_now & scl_d & ~sda_d & sda_now;
endmodule

// File: rtl/twr_regbank.sv
module twr_regbank #(
  parameter int AW = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                addr,
  input  logic [twr_pkg::BYTE_W-1:0]   wr_data,
  output logic [twr_pkg::BYTE_W-1:0]   rd_data,
  output logic [(2**AW)*twr_pkg::BYTE_W-1:0] regs_flat
);
  localparam int NREG = 2**AW;
  localparam int DW   = twr_pkg::BYTE_W;

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  assign rd_data = mem[addr];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = mem[g];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(addr)] == $past(wr_data)); // R4
endmodule

// File: rtl/twr_proto.sv
module twr_proto #(
  parameter int          AW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sda_lvl,
  input  logic                       scl_rise,
  input  logic                       scl_fall,
  input  logic                       start_det,
  input  logic                       stop_det,
  input  logic [twr_pkg::BYTE_W-1:0] rd_data,
  output logic                       wr_en,
  output logic [twr_pkg::BYTE_W-1:0] wr_data,
  output logic [AW-1:0]              ptr,
  output logic                       sda_oe
);
  import twr_pkg::*;
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_W);

  twr_state_e        state;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              rw_q;

  assign wr_en   = (state == ST_WR) && scl_fall && (cnt == CNT_FULL)
                   && !start_det && !stop_det;
  assign wr_data = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      rw_q   <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_REG, ST_WR: begin
          if (scl_rise && cnt != CNT_FULL) begin
            sh  <= {sh[BYTE_W-2:0], sda_lvl};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            cnt <= '0;
            if (state == ST_DEV) begin
              if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                rw_q   <= sh[0];
                sda_oe <= 1'b1;
                state  <= ST_DEVACK;
              end else begin
                state  <= ST_IGNORE;
              end
            end else if (state == ST_REG) begin
              ptr    <= sh[AW-1:0];
              sda_oe <= 1'b1;
              state  <= ST_REGACK;
            end else begin
              ptr    <= ptr + 1'b1;
              sda_oe <= 1'b1;
              state  <= ST_WRACK;
            end
          end
        end
        ST_DEVACK, ST_REGACK, ST_WRACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (state == ST_DEVACK && rw_q) begin
              sda_oe <= ~rd_data[BYTE_W-1];
              tx     <= {rd_data[BYTE_W-2:0], 1'b0};
              cnt    <= CW'(1);
              ptr    <= ptr + 1'b1;
              state  <= ST_RD;
            end else if (state == ST_DEVACK) begin
              state <= ST_REG;
            end else begin
              state <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt == CNT_FULL) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              sda_oe <= ~tx[BYTE_W-1];
              tx     <= {tx[BYTE_W-2:0], 1'b0};
              cnt    <= cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise && sda_lvl) begin
            state <= ST_IGNORE;
          end else if (scl_fall) begin
            sda_oe <= ~rd_data[BYTE_W-1];
            tx     <= {rd_data[BYTE_W-2:0], 1'b0};
            cnt    <= CW'(1);
            ptr    <= ptr + 1'b1;
            state  <= ST_RD;
          end
        end
        default: state <= state;
      endcase
    end
  end

  AST_START_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_DEV && !sda_oe)); // R2

  AST_OE_ONLY_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state inside {ST_DEVACK, ST_REGACK, ST_WRACK, ST_RD})); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == AW'($past(ptr) + 1'b1)); // R5

  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MACK && scl_rise && sda_lvl && !start_det && !stop_det)
      |=> (state == ST_IGNORE && !sda_oe)); // R7

  AST_OE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R8
endmodule

// File: rtl/twr_regslave.sv
module twr_regslave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  scl_i,
  input  logic                                  sda_i,
  output logic                                  sda_oe,
  output logic [(2**AW)*twr_pkg::BYTE_W-1:0]    regs_flat
);
  import twr_pkg::*;

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [AW-1:0] ptr;

  twr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twr_proto #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr),
    .sda_oe(sda_oe)
  );

  twr_regbank #(.AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr),
    .wr_data(wr_data), .rd_data(rd_data), .regs_flat(regs_flat)
  );
endmodule

// File: tb/twr_regslave_test.sv
module twr_regslave_test;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [2047:0] regs;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int fails = 0;
  int oe_viol = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  twr_regslave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_flat(regs)
  );

  // R8 monitor: pull-down must not move while the clock line is high
  logic oe_prev = 1'b0;
  logic scl_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n && scl && scl_prev && (sda_oe != oe_prev)) oe_viol++;
    oe_prev  <= sda_oe;
    scl_prev <= scl;
  end

  function automatic logic [7:0] pat(int i);
    return 8'((i * 29 + 11) & 255);
  endfunction

  function automatic logic [7:0] reg_at(int k);
    return regs[k*8 +: 8];
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~mack);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic b;
    logic [7:0] v;
    logic [7:0] exp_rd [4];
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    wq();

    // R1: reset state
    check(sda_oe == 1'b0, "R1 released", int'(sda_oe), 0);
    check(regs == '0, "R1 regs zero", int'(regs[31:0]), 0);

    // R3 R4: full burst over the whole map
    bus_start();
    send_byte(8'hD2, ak);
    check(ak, "R3 address ack", int'(ak), 1);
    send_byte(8'h00, ak);
    check(ak, "R4 pointer ack", int'(ak), 1);
    for (int i = 0; i < 256; i++) begin
      send_byte(pat(i), ak);
      check(ak, "R4 data ack", int'(ak), 1);
    end
    bus_stop();
    for (int k = 0; k < 256; k++)
      check(reg_at(k) == pat(k), "R4 stored byte", int'(reg_at(k)), int'(pat(k)));

    // R5: wrap from 0xFF to 0x00
    bus_start();
    send_byte(8'hD2, ak);
    send_byte(8'hFE, ak);
    send_byte(8'hA1, ak);
    send_byte(8'hB2, ak);
    send_byte(8'hC3, ak);
    bus_stop();
    check(reg_at(254) == 8'hA1, "R5 reg FE", int'(reg_at(254)), 'hA1);
    check(reg_at(255) == 8'hB2, "R5 reg FF", int'(reg_at(255)), 'hB2);
    check(reg_at(0) == 8'hC3, "R5 wrap to 00", int'(reg_at(0)), 'hC3);
    check(reg_at(1) == pat(1), "R5 reg 01 untouched", int'(reg_at(1)), int'(pat(1)));

    // R6 R7: read across the wrap, NACK on the last byte
    exp_rd[0] = pat(253); exp_rd[1] = 8'hA1; exp_rd[2] = 8'hB2; exp_rd[3] = 8'hC3;
    bus_start();
    send_byte(8'hD2, ak);
    send_byte(8'hFD, ak);
    bus_start();
    send_byte(8'hD3, ak);
    check(ak, "R6 read address ack", int'(ak), 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(v, i < 3);
      check(v == exp_rd[i], "R6 read byte", int'(v), int'(exp_rd[i]));
    end
    get_bit(b);
    check(b == 1'b1, "R7 released after NACK", int'(b), 1);
    bus_stop();

    // R3: sweep every device address; only 0x69 acknowledges
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte(8'(a << 1), ak);
      check(ak == (a == 'h69), "R3 address match", int'(ak), int'(a == 'h69));
      send_byte(8'h40, ak);
      send_byte(8'hEE, ak);
      bus_stop();
    end
    check(reg_at('h40) == 8'hEE, "R3 matched write", int'(reg_at('h40)), 'hEE);
    check(reg_at('h41) == pat('h41), "R3 ignored frames", int'(reg_at('h41)), int'(pat('h41)));

    // R9 R2: bytes cut by stop or by a repeated start are dropped
    bus_start();
    send_byte(8'hD2, ak);
    send_byte(8'h30, ak);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    check(reg_at('h30) == pat('h30), "R9 partial byte at stop", int'(reg_at('h30)), int'(pat('h30)));
    bus_start();
    send_byte(8'hD2, ak);
    send_byte(8'h31, ak);
    send_byte(8'h77, ak);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_start();
    send_byte(8'hD2, ak);
    check(ak, "R2 start restarts frame", int'(ak), 1);
    send_byte(8'h33, ak);
    send_byte(8'h66, ak);
    bus_stop();
    check(reg_at('h31) == 8'h77, "R9 whole byte kept", int'(reg_at('h31)), 'h77);
    check(reg_at('h32) == pat('h32), "R9 partial byte at start", int'(reg_at('h32)), int'(pat('h32)));
    check(reg_at('h33) == 8'h66, "R2 new frame write", int'(reg_at('h33)), 'h66);

    // R8: output never moved with the clock line high
    check(oe_viol == 0, "R8 output timing", oe_viol, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule